// File: doc/BRIEF.md
# Four-Port Burst-Budget Command Arbiter

This block sits between four command-issuing masters and four memory pseudo-channel targets. Each master presents one command at a time, tagged with the target it wants to reach. Any master may address any of the four targets. Every target has its own arbitration slot, which decides which master currently owns it. Only commands from the owning master are passed through, and the slot publishes the owner's index so that an external data multiplexer can steer data to match.

Ownership is measured in memory transactions, not beats. A transaction is one 32-byte burst or one paired 64-byte burst, and each accepted command counts as one. Every master has a programmed 16-bit budget. That budget is shared across all targets the master visits during one ownership period. Ownership changes only at a grant boundary: the budget runs out, or the owner stops asking for that target. At a boundary the slot serves masters round-robin. If a preferred master is configured and it is requesting, it wins instead.

Top module: `hbx_xbar_arb`

## Requirements
- R1: While reset is active, and in the first cycle after it, no target has an owner, every `tgt_valid` is low and every `mst_ready` is low.
- R2: A master's command is visible only on the target named by its 2-bit target field (0..3). A command is accepted in the cycle where `mst_valid` and `mst_ready` are both high. `mst_ready` is high only when the master owns that target and the target's `tgt_ready` is high. `tgt_owner` gives the owning master's index.
- R3: An idle target with requesters takes a new owner at the next clock edge. The owner's command appears in the cycle after it was first requested.
- R4: With a programmed budget N ≥ 1, a master may issue at most N accepted commands per ownership period. These are counted across every target it visits in that period. After the N-th command, ownership passes on.
- R5: A budget of 0 allows exactly one accepted command per ownership period.
- R6: Ownership of a target ends early in the same cycle that the owner stops requesting it, either by dropping `mst_valid` or by naming another target.
- R7: With no preferred master, a boundary scan starts at the master after the one whose ownership just ended. After reset, the first scan starts at master 0.
- R8: When `pref_en` is high and master `pref_id` requests a target at a grant boundary, that master becomes the owner.
- R9: A preferred master never takes a target from an owner that is still requesting it and still has budget left.
- R10: The four targets arbitrate independently. Commands to different targets can be accepted in the same cycle.
- R11: A master owns at most one target at any time.
- R12: While `tgt_ready` is low, the owner keeps the target as long as it keeps requesting. No command is accepted and `tgt_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_txn_count | input | 64 | Per-master budget, 16 bits each; master m uses bits [16m+15:16m] |
| pref_en | input | 1 | Enables the preferred master |
| pref_id | input | 2 | Index of the preferred master |
| mst_valid | input | 4 | Per-master command valid |
| mst_target | input | 8 | Per-master target index, 2 bits each; master m uses bits [2m+1:2m] |
| mst_ready | output | 4 | Per-master command accepted |
| tgt_valid | output | 4 | Per-target command valid toward memory |
| tgt_ready | input | 4 | Per-target back-pressure from memory |
| tgt_owner | output | 8 | Per-target owning master index, 2 bits each |
| tgt_busy | output | 4 | Per-target ownership held |

## Verification
Two masters sharing one target with budgets 3 and 2 show whether ownership lasts a whole budget or a single beat. Four masters with zero budgets show the one-command rule and the rotating start of the round-robin scan. Starting the preferred master while a long budget is running shows whether preference waits for the boundary. A master that drops its request early, and a master that moves to a second target part-way through its budget, show early release and the shared budget. Stalls, and four masters on four different targets, show that ownership holds under back-pressure and that the slots run independently.

// File: rtl/hbx_pkg.sv
package hbx_pkg;
  localparam int unsigned HBX_PORTS = 4;
  localparam int unsigned HBX_CNT_W = 16;

  // Next index in a ring of n entries.
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/hbx_budget.sv
module hbx_budget #(
  parameter int unsigned CNT_W = hbx_pkg::HBX_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             fire,
  input  logic             held,
  output logic             done
);
  logic [CNT_W-1:0] used;
  logic [CNT_W-1:0] lim;

  // Budget of zero behaves like one.
  assign lim  = (cfg_count == '0) ? '0 : cfg_count - 1'b1;
  assign done = fire && (used >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n)       used <= '0;
    else if (done)    used <= '0;
    else if (fire)    used <= used + 1'b1;
    else if (!held)   used <= '0;
  end

  AST_BUDGET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    used <= lim); // R4
  AST_ZERO_IS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cfg_count == '0) |=> (used == '0)); // R5
endmodule

// File: rtl/hbx_pick.sv
module hbx_pick #(
  parameter int unsigned N = hbx_pkg::HBX_PORTS,
  parameter int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] start,
  input  logic         pref_en,
  input  logic [W-1:0] pref_id,
  output logic         any,
  output logic [W-1:0] win
);
  always_comb begin
    logic found;
    found = 1'b0;
    win   = start;
    any   = |req;
    for (int off = 0; off < int'(N); off++) begin
      int unsigned idx;
      idx = (int'(start) + off) % N;
      if (!found && req[idx]) begin
        win   = W'(idx);
        found = 1'b1;
      end
    end
    if (pref_en && (int'(pref_id) < int'(N)) && req[pref_id]) win = pref_id;
  end
endmodule

// File: rtl/hbx_slot.sv
module hbx_slot #(
  parameter int unsigned N = hbx_pkg::HBX_PORTS,
  parameter int unsigned W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] done,
  input  logic         pref_en,
  input  logic [W-1:0] pref_id,
  output logic         owner_vld,
  output logic [W-1:0] owner_id
);
  logic [W-1:0] ptr;
  logic [W-1:0] nxt;
  logic [W-1:0] start;
  logic [W-1:0] win;
  logic         any;
  logic         own_req;
  logic         own_done;
  logic         rel;
  logic         arb_go;

  assign own_req  = owner_vld && req[owner_id];
  assign own_done = owner_vld && done[owner_id];
  assign rel      = owner_vld && (!own_req || own_done);
  assign arb_go   = !owner_vld || rel;
  assign nxt      = W'(hbx_pkg::ring_next(int'(owner_id), N));
  assign start    = rel ? nxt : ptr;

  hbx_pick #(.N(N), .W(W)) u_pick (
    .req     (req),
    .start   (start),
    .pref_en (pref_en),
    .pref_id (pref_id),
    .any     (any),
    .win     (win)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_vld <= 1'b0;
      owner_id  <= '0;
      ptr       <= '0;
    end else begin
      if (rel) ptr <= nxt;
      if (arb_go) begin
        owner_vld <= any;
        if (any) owner_id <= win;
      end
    end
  end

  AST_PREF_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_go && pref_en && req[pref_id]) |=> (owner_vld && owner_id == $past(pref_id))); // R8
  AST_HOLD_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_vld && req[owner_id] && !done[owner_id]) |=> (owner_vld && $stable(owner_id))); // R9
endmodule

// File: rtl/hbx_xbar_arb.sv
module hbx_xbar_arb #(
  parameter int unsigned NUM_M = hbx_pkg::HBX_PORTS,
  parameter int unsigned NUM_T = hbx_pkg::HBX_PORTS,
  parameter int unsigned CNT_W = hbx_pkg::HBX_CNT_W,
  localparam int unsigned MW   = $clog2(NUM_M),
  localparam int unsigned TW   = $clog2(NUM_T)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_M*CNT_W-1:0] cfg_txn_count,
  input  logic                   pref_en,
  input  logic [MW-1:0]          pref_id,
  input  logic [NUM_M-1:0]       mst_valid,
  input  logic [NUM_M*TW-1:0]    mst_target,
  output logic [NUM_M-1:0]       mst_ready,
  output logic [NUM_T-1:0]       tgt_valid,
  input  logic [NUM_T-1:0]       tgt_ready,
  output logic [NUM_T*MW-1:0]    tgt_owner,
  output logic [NUM_T-1:0]       tgt_busy
);
  logic [NUM_T-1:0][NUM_M-1:0] req_map;
  logic [NUM_M-1:0][NUM_T-1:0] held_map;
  logic [NUM_M-1:0][NUM_T-1:0] acc_map;
  logic [NUM_T-1:0][MW-1:0]    own_id;
  logic [NUM_T-1:0]            own_vld;
  logic [NUM_M-1:0]            fire;
  logic [NUM_M-1:0]            held;
  logic [NUM_M-1:0]            done;

  for (genvar t = 0; t < NUM_T; t++) begin : g_map
    for (genvar m = 0; m < NUM_M; m++) begin : g_m
      assign req_map[t][m]  = mst_valid[m] && (mst_target[m*TW +: TW] == TW'(t));
      assign held_map[m][t] = own_vld[t] && (own_id[t] == MW'(m));
      assign acc_map[m][t]  = held_map[m][t] && req_map[t][m] && tgt_ready[t];
    end
  end

  for (genvar t = 0; t < NUM_T; t++) begin : g_slot
    hbx_slot #(.N(NUM_M), .W(MW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req_map[t]),
      .done      (done),
      .pref_en   (pref_en),
      .pref_id   (pref_id),
      .owner_vld (own_vld[t]),
      .owner_id  (own_id[t])
    );
    assign tgt_valid[t]             = own_vld[t] && req_map[t][own_id[t]];
    assign tgt_owner[t*MW +: MW]    = own_id[t];
    assign tgt_busy[t]              = own_vld[t];
  end

  for (genvar m = 0; m < NUM_M; m++) begin : g_mst
    assign mst_ready[m] = |acc_map[m];
    assign held[m]      = |held_map[m];
    assign fire[m]      = mst_valid[m] && mst_ready[m];

    hbx_budget #(.CNT_W(CNT_W)) u_budget (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_count (cfg_txn_count[m*CNT_W +: CNT_W]),
      .fire      (fire[m]),
      .held      (held[m]),
      .done      (done[m])
    );

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(held_map[m])); // R11
    AST_READY_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
      mst_ready[m] |-> (tgt_valid[mst_target[m*TW +: TW]] && tgt_ready[mst_target[m*TW +: TW]])); // R2
  end
endmodule

// File: tb/hbx_xbar_arb_tb.sv
module hbx_xbar_arb_tb;
  localparam int NM = 4;
  localparam int NT = 4;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NM*CW-1:0] cfg_txn_count = '0;
  logic          pref_en = 1'b0;
  logic [1:0]    pref_id = '0;
  logic [NM-1:0] mst_valid = '0;
  logic [NM*2-1:0] mst_target = '0;
  logic [NM-1:0] mst_ready;
  logic [NT-1:0] tgt_valid;
  logic [NT-1:0] tgt_ready = '1;
  logic [NT*2-1:0] tgt_owner;
  logic [NT-1:0] tgt_busy;

  int n_chk = 0;
  int n_bad = 0;
  int log_m[64];
  int log_t[64];
  int nlog = 0;
  int fires_now = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hbx_xbar_arb u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_txn_count(cfg_txn_count),
    .pref_en(pref_en), .pref_id(pref_id),
    .mst_valid(mst_valid), .mst_target(mst_target), .mst_ready(mst_ready),
    .tgt_valid(tgt_valid), .tgt_ready(tgt_ready), .tgt_owner(tgt_owner),
    .tgt_busy(tgt_busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; mst_valid = '0; mst_target = '0; tgt_ready = '1;
    pref_en = 1'b0; pref_id = '0; cfg_txn_count = '0;
    nlog = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic release_reset();
    rst_n = 1'b1;
  endtask

  task automatic set_cnt(input int m, input int v);
    cfg_txn_count[m*CW +: CW] = CW'(v);
  endtask

  task automatic drive(input int m, input bit v, input int t);
    mst_valid[m] = v;
    mst_target[m*2 +: 2] = 2'(t);
  endtask

  // Records accepts that commit at the coming edge, then moves past it.
  task automatic step();
    @(negedge clk);
    fires_now = 0;
    for (int m = 0; m < NM; m++) begin
      if (mst_valid[m] && mst_ready[m]) begin
        fires_now++;
        if (nlog < 64) begin
          log_m[nlog] = m;
          log_t[nlog] = int'(mst_target[m*2 +: 2]);
          nlog++;
        end
      end
    end
    @(posedge clk);
    #5;
  endtask

  task automatic run_until(input int n);
    for (int i = 0; i < 200 && nlog < n; i++) step();
  endtask

  task automatic t_reset_and_latency();
    do_reset();
    drive(0, 1, 0);
    @(negedge clk);
    chk("R1 ready in reset", int'(mst_ready), 0);
    chk("R1 valid in reset", int'(tgt_valid), 0);
    chk("R1 busy in reset", int'(tgt_busy), 0);
    release_reset();
    #1;
    chk("R1 valid first cycle", int'(tgt_valid), 0);
    @(negedge clk);
    chk("R3 owner taken", int'(tgt_busy[0]), 1);
    chk("R3 valid next cycle", int'(tgt_valid[0]), 1);
    chk("R2 owner index", int'(tgt_owner[1:0]), 0);
    chk("R2 other targets idle", int'(tgt_valid[3:1]), 0);
  endtask

  task automatic t_budget_pair();
    int exp[10] = '{0,0,0,1,1,0,0,0,1,1};
    do_reset();
    set_cnt(0, 3); set_cnt(1, 2);
    drive(0, 1, 2); drive(1, 1, 2);
    release_reset();
    run_until(10);
    for (int i = 0; i < 10; i++) chk("R4 budget order", log_m[i], exp[i]);
    chk("R2 target of accepts", log_t[4], 2);
  endtask

  task automatic t_zero_rr();
    do_reset();
    for (int m = 0; m < NM; m++) begin set_cnt(m, 0); drive(m, 1, 1); end
    release_reset();
    run_until(8);
    for (int i = 0; i < 8; i++) chk("R5 R7 one each in turn", log_m[i], i % 4);
  endtask

  task automatic t_rr_sparse();
    int exp[4] = '{1,3,1,3};
    do_reset();
    drive(1, 1, 3); drive(3, 1, 3);
    release_reset();
    run_until(4);
    for (int i = 0; i < 4; i++) chk("R7 scan after ended owner", log_m[i], exp[i]);
  endtask

  task automatic t_pref_boundary();
    int exp[8] = '{0,0,0,0,2,2,2,2};
    do_reset();
    set_cnt(0, 4); set_cnt(1, 1); set_cnt(2, 2);
    pref_en = 1'b1; pref_id = 2'd2;
    drive(0, 1, 0); drive(1, 1, 0);
    release_reset();
    run_until(1);
    drive(2, 1, 0);
    run_until(8);
    for (int i = 0; i < 4; i++) chk("R9 no preemption", log_m[i], exp[i]);
    for (int i = 4; i < 8; i++) chk("R8 preferred wins", log_m[i], exp[i]);
  endtask

  task automatic t_early_release();
    int n1;
    do_reset();
    set_cnt(1, 5); set_cnt(3, 1);
    drive(1, 1, 3); drive(3, 1, 3);
    release_reset();
    run_until(2);
    drive(1, 0, 3);
    run_until(3);
    n1 = 0;
    for (int i = 0; i < nlog; i++) if (log_m[i] == 1) n1++;
    chk("R6 owner accepts before drop", n1, 2);
    chk("R6 next owner", log_m[2], 3);
  endtask

  task automatic t_shared_budget();
    do_reset();
    set_cnt(0, 4); set_cnt(1, 1);
    drive(0, 1, 0);
    release_reset();
    run_until(2);
    drive(0, 1, 1); drive(1, 1, 1);
    run_until(5);
    chk("R4 shared m0 t1 first", log_m[2], 0);
    chk("R4 shared m0 t1 second", log_m[3], 0);
    chk("R4 shared budget ends", log_m[4], 1);
    chk("R6 moved target", log_t[2], 1);
  endtask

  task automatic t_backpressure();
    do_reset();
    set_cnt(2, 2);
    tgt_ready = 4'b1110;
    drive(2, 1, 0); drive(3, 1, 0);
    release_reset();
    step();
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R12 no accept in stall", fires_now, 0);
      chk("R12 valid held", int'(tgt_valid[0]), 1);
      chk("R12 owner kept", int'(tgt_owner[1:0]), 2);
    end
    tgt_ready = '1;
    run_until(3);
    chk("R12 owner first after stall", log_m[0], 2);
    chk("R4 owner second", log_m[1], 2);
    chk("R7 next owner", log_m[2], 3);
  endtask

  task automatic t_parallel();
    int best;
    do_reset();
    for (int m = 0; m < NM; m++) drive(m, 1, m);
    release_reset();
    best = 0;
    for (int i = 0; i < 4; i++) begin
      step();
      if (fires_now > best) best = fires_now;
    end
    chk("R10 four accepts in one cycle", best, 4);
  endtask

  initial begin
    for (int c = 0; c < 150000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset_and_latency();
    t_budget_pair();
    t_zero_rr();
    t_rr_sparse();
    t_pref_boundary();
    t_early_release();
    t_shared_budget();
    t_backpressure();
    t_parallel();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule